// File: doc/BRIEF.md
# Hit-Count Hot Page Tiering Tracker

This block watches a stream of page accesses and sorts every logical page into one of three mapping tiers. Pages start in the coarse tier. A page that is hit often enough moves into a larger fine-grained "warm" table. A warm page that keeps being hit moves into a smaller fine-grained "hot" table. Each page keeps a saturating hit counter and two recently-used flags, one for reads and one for writes. A programmable sweep timer periodically evaluates the flags. Any fine-grained page whose flags are both clear is sent back to the coarse tier. After that evaluation, every flag is cleared.

The block drives a one-cycle promote event carrying the page and its new tier, and a one-cycle demote mask with one bit per page. An address translator uses these events to move mappings between its tables. The warm and hot tables have fixed capacities. A promotion that would overfill its destination table is held back until space frees. Both hit thresholds and the sweep period are runtime inputs. A combinational query port reports the current tier and hit count of any page.

Top module: `hot_page_tiering`

## Requirements
- R1: After reset every page is coarse (tier code 0) with hit count 0, `promo_valid` is 0 and `demo_mask` is 0.
- R2: Each access to a coarse (code 0) or warm (code 1) page that causes no promotion raises that page's count by one. The new count is visible on the query port after the clock edge that takes the access.
- R3: When an access takes a coarse page's incremented count strictly above `thr_warm` and the warm table holds fewer than WARM_CAP pages, the page becomes warm with count 0. In the following cycle `promo_valid`=1, `promo_page` is that page and `promo_tier`=1.
- R4: When an access takes a warm page's incremented count strictly above `thr_hot` and the hot table holds fewer than HOT_CAP pages, the page becomes hot (code 2) with count 0, and `promo_tier`=2 is reported.
- R5: If the destination table is full, no promote event is issued, the tier is unchanged and the count is set equal to the crossed threshold. The next access after space frees then promotes the page.
- R6: An access sets the page's read flag (`acc_write`=0) or its write flag (`acc_write`=1). At a sweep, each warm or hot page with both flags clear returns to coarse with count 0. Its bit i (i = page number) in `demo_mask` is 1 in the cycle after the sweep edge.
- R7: At every sweep all flags are cleared after evaluation. A fine-grained page not accessed again before the next sweep is demoted by that sweep.
- R8: With `sweep_period`=P>0, a sweep occurs at every P-th clock edge, counted from reset or from the previous sweep. P=0 disables sweeps.
- R9: Hit counts saturate at 2^CNT_W-1. Hot pages are never promoted further. Coarse pages never appear in `demo_mask`.
- R10: An access taken on the same edge as a sweep counts as recent use, so its page is not demoted by that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access event present this cycle |
| acc_page | input | PAGE_W | Logical page of the access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| thr_warm | input | CNT_W | Coarse-to-warm hit threshold |
| thr_hot | input | CNT_W | Warm-to-hot hit threshold |
| sweep_period | input | PER_W | Cycles between sweeps, 0 = off |
| qry_page | input | PAGE_W | Page whose state is reported |
| qry_tier | output | 2 | Tier of `qry_page` (0 coarse, 1 warm, 2 hot) |
| qry_count | output | CNT_W | Hit count of `qry_page` |
| promo_valid | output | 1 | Promotion happened on the last edge |
| promo_page | output | PAGE_W | Promoted page |
| promo_tier | output | 2 | Tier the page moved into |
| demo_mask | output | NUM_PAGES | Pages demoted on the last edge |

## Verification
The bench aims at the full-table case first. A design that dropped the capacity check would emit a promotion into a full table. A design that forgot the clamp would leave the count above the threshold or would not retry after a sweep frees space. The bench also places an access exactly on a sweep edge. A tracker that evaluated the flags before merging that access would wrongly demote a page in active use. Further tests cover two sweeps in a row, which catch a design that never clears the flags, and a zero period, which must stop all demotion. Counter saturation on a hot page is checked through the query port.

// File: rtl/hot_tier_pkg.sv
`timescale 1ns/1ps
// Package: shared tier encoding for the hot page tiering tracker.
// Assumes: codes 0..2 are decoded by the translator; code 3 is unused.
package hot_tier_pkg;
    typedef enum logic [1:0] {
        TIER_COARSE = 2'd0,
        TIER_WARM   = 2'd1,
        TIER_HOT    = 2'd2
    } tier_e;
endpackage

// File: rtl/hot_sweep_timer.sv
`timescale 1ns/1ps
// Module: hot_sweep_timer
// Produces a one-cycle sweep strobe every `period` clock edges.
// Assumes: period may change at run time; a running count already at or
// beyond the new limit fires at once. Period 0 holds the timer idle.
module hot_sweep_timer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic [PER_W-1:0] elapsed;

    // Strobe when the elapsed count reaches the last cycle of the period.
    always_comb tick = (period != '0) && (elapsed >= period - ONE);

    // Count cycles, restarting after each strobe or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            elapsed <= '0;
        else if (period == '0 || tick)
            elapsed <= '0;
        else
            elapsed <= elapsed + ONE;
    end
endmodule

// File: rtl/hot_promote_ctl.sv
`timescale 1ns/1ps
// Module: hot_promote_ctl
// Decides the next tier and count of the page being accessed.
// Assumes: at most one access per cycle; occupancies are the values
// before this cycle's sweep, so capacity is judged conservatively.
module hot_promote_ctl
    import hot_tier_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int WARM_CAP = 4,
    parameter int HOT_CAP  = 2,
    parameter int WOCC_W   = 3,
    parameter int HOCC_W   = 2
) (
    input  tier_e              cur_tier,
    input  logic [CNT_W-1:0]   cur_cnt,
    input  logic [CNT_W-1:0]   thr_warm,
    input  logic [CNT_W-1:0]   thr_hot,
    input  logic [WOCC_W-1:0]  warm_occ,
    input  logic [HOCC_W-1:0]  hot_occ,
    output tier_e              nxt_tier,
    output logic [CNT_W-1:0]   nxt_cnt,
    output logic               promote
);
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
    localparam logic [WOCC_W-1:0] WARM_LIM = WOCC_W'(WARM_CAP);
    localparam logic [HOCC_W-1:0] HOT_LIM  = HOCC_W'(HOT_CAP);

    logic [CNT_W-1:0] bumped;

    // Saturating increment followed by threshold and capacity decision.
    always_comb begin
        bumped   = (cur_cnt == CNT_MAX) ? cur_cnt : cur_cnt + CNT_W'(1);
        nxt_tier = cur_tier;
        nxt_cnt  = bumped;
        promote  = 1'b0;
        case (cur_tier)
            TIER_COARSE: if (bumped > thr_warm) begin
                if (warm_occ < WARM_LIM) begin
                    nxt_tier = TIER_WARM;
                    nxt_cnt  = '0;
                    promote  = 1'b1;
                end else begin
                    nxt_cnt  = thr_warm;
                end
            end
            TIER_WARM: if (bumped > thr_hot) begin
                if (hot_occ < HOT_LIM) begin
                    nxt_tier = TIER_HOT;
                    nxt_cnt  = '0;
                    promote  = 1'b1;
                end else begin
                    nxt_cnt  = thr_hot;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hot_page_cell.sv
`timescale 1ns/1ps
// Module: hot_page_cell
// Holds tier, hit count and read/write recently-used flags of one page,
// merges an access, and applies the sweep to the merged state.
// Assumes: upd_tier/upd_cnt are meaningful only while sel is high.
module hot_page_cell
    import hot_tier_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             is_wr,
    input  tier_e            upd_tier,
    input  logic [CNT_W-1:0] upd_cnt,
    input  logic             sweep,
    output tier_e            tier,
    output logic [CNT_W-1:0] cnt,
    output logic             drop_warm,
    output logic             drop_hot
);
    logic             rd_seen, wr_seen;
    tier_e            eff_tier;
    logic [CNT_W-1:0] eff_cnt;
    logic             eff_rd, eff_wr, stale;

    // State as it stands after this cycle's access, before the sweep.
    always_comb begin
        eff_tier  = sel ? upd_tier : tier;
        eff_cnt   = sel ? upd_cnt : cnt;
        eff_rd    = rd_seen | (sel & ~is_wr);
        eff_wr    = wr_seen | (sel & is_wr);
        stale     = sweep && (eff_tier != TIER_COARSE) && !eff_rd && !eff_wr;
        drop_warm = stale && (eff_tier == TIER_WARM);
        drop_hot  = stale && (eff_tier == TIER_HOT);
    end

    // Commit merged state; sweep demotes stale pages and clears flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tier    <= TIER_COARSE;
            cnt     <= '0;
            rd_seen <= 1'b0;
            wr_seen <= 1'b0;
        end else begin
            tier    <= stale ? TIER_COARSE : eff_tier;
            cnt     <= stale ? '0 : eff_cnt;
            rd_seen <= sweep ? 1'b0 : eff_rd;
            wr_seen <= sweep ? 1'b0 : eff_wr;
        end
    end
endmodule

// File: rtl/hot_page_tiering.sv
`timescale 1ns/1ps
// Module: hot_page_tiering (top)
// Classifies logical pages into coarse, warm and hot tiers from hit counts
// and recently-used flags; reports promotions and sweep demotions.
// Assumes: NUM_PAGES is a power of two; one access per cycle at most.
module hot_page_tiering
    import hot_tier_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int CNT_W     = 4,
    parameter int WARM_CAP  = 4,
    parameter int HOT_CAP   = 2,
    parameter int PER_W     = 8,
    localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic [PAGE_W-1:0]    acc_page,
    input  logic                 acc_write,
    input  logic [CNT_W-1:0]     thr_warm,
    input  logic [CNT_W-1:0]     thr_hot,
    input  logic [PER_W-1:0]     sweep_period,
    input  logic [PAGE_W-1:0]    qry_page,
    output logic [1:0]           qry_tier,
    output logic [CNT_W-1:0]     qry_count,
    output logic                 promo_valid,
    output logic [PAGE_W-1:0]    promo_page,
    output logic [1:0]           promo_tier,
    output logic [NUM_PAGES-1:0] demo_mask
);
    localparam int WOCC_W = $clog2(WARM_CAP + 1);
    localparam int HOCC_W = $clog2(HOT_CAP + 1);

    tier_e                 cell_tier [NUM_PAGES];
    logic [CNT_W-1:0]      cell_cnt  [NUM_PAGES];
    logic [NUM_PAGES-1:0]  drop_warm_v, drop_hot_v;
    logic [WOCC_W-1:0]     warm_occ;
    logic [HOCC_W-1:0]     hot_occ;
    logic                  sweep;
    tier_e                 cur_tier, nxt_tier;
    logic [CNT_W-1:0]      cur_cnt, nxt_cnt;
    logic                  promote, promo_hit, into_warm, outof_warm;

    hot_sweep_timer #(.PER_W(PER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .period(sweep_period), .tick(sweep)
    );

    // Select the accessed page's current state for the decision logic.
    always_comb begin
        cur_tier   = cell_tier[acc_page];
        cur_cnt    = cell_cnt[acc_page];
        promo_hit  = acc_valid && promote;
        into_warm  = promo_hit && (cur_tier == TIER_COARSE);
        outof_warm = promo_hit && (cur_tier == TIER_WARM);
    end

    hot_promote_ctl #(
        .CNT_W(CNT_W), .WARM_CAP(WARM_CAP), .HOT_CAP(HOT_CAP),
        .WOCC_W(WOCC_W), .HOCC_W(HOCC_W)
    ) u_ctl (
        .cur_tier(cur_tier), .cur_cnt(cur_cnt),
        .thr_warm(thr_warm), .thr_hot(thr_hot),
        .warm_occ(warm_occ), .hot_occ(hot_occ),
        .nxt_tier(nxt_tier), .nxt_cnt(nxt_cnt), .promote(promote)
    );

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        logic page_sel;
        assign page_sel = acc_valid && (acc_page == PAGE_W'(g));
        hot_page_cell #(.CNT_W(CNT_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .sel(page_sel), .is_wr(acc_write),
            .upd_tier(nxt_tier), .upd_cnt(nxt_cnt), .sweep(sweep),
            .tier(cell_tier[g]), .cnt(cell_cnt[g]),
            .drop_warm(drop_warm_v[g]), .drop_hot(drop_hot_v[g])
        );
    end

    // Track table occupancy from promotions in and sweep demotions out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_occ <= '0;
            hot_occ  <= '0;
        end else begin
            warm_occ <= warm_occ + WOCC_W'(into_warm) - WOCC_W'(outof_warm)
                        - WOCC_W'($countones(drop_warm_v));
            hot_occ  <= hot_occ + HOCC_W'(outof_warm)
                        - HOCC_W'($countones(drop_hot_v));
        end
    end

    // Register the promote and demote events for the translator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            promo_valid <= 1'b0;
            promo_page  <= '0;
            promo_tier  <= 2'd0;
            demo_mask   <= '0;
        end else begin
            promo_valid <= promo_hit;
            promo_page  <= acc_page;
            promo_tier  <= nxt_tier;
            demo_mask   <= drop_warm_v | drop_hot_v;
        end
    end

    // Report the queried page's tier and count directly from the cells.
    always_comb begin
        qry_tier  = cell_tier[qry_page];
        qry_count = cell_cnt[qry_page];
    end
endmodule

// File: rtl/hot_tier_checker.sv
`timescale 1ns/1ps
// Module: hot_tier_checker
// Protocol and capacity properties of hot_page_tiering, bound to the top.
module hot_tier_checker #(
    parameter int NUM_PAGES = 16,
    parameter int WARM_CAP  = 4,
    parameter int HOT_CAP   = 2,
    parameter int PER_W     = 8,
    localparam int WOCC_W   = $clog2(WARM_CAP + 1),
    localparam int HOCC_W   = $clog2(HOT_CAP + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_valid,
    input logic                 promo_valid,
    input logic [1:0]           promo_tier,
    input logic [NUM_PAGES-1:0] demo_mask,
    input logic                 sweep,
    input logic [PER_W-1:0]     sweep_period,
    input logic [WOCC_W-1:0]    warm_occ,
    input logic [HOCC_W-1:0]    hot_occ
);
    // A promotion event needs an access on the previous edge.
    assert_promo_after_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        promo_valid |-> $past(acc_valid));

    // Promotions only ever land in the warm or hot tier.
    assert_promo_tier_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        promo_valid |-> (promo_tier == 2'd1 || promo_tier == 2'd2));

    // Fine-grained tables never exceed their capacities.
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_occ <= WOCC_W'(WARM_CAP)) && (hot_occ <= HOCC_W'(HOT_CAP)));

    // Demotions only follow a sweep edge.
    assert_demote_after_sweep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (demo_mask != '0) |-> $past(sweep));

    // A zero period keeps the sweep idle.
    assert_sweep_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_period == '0) |-> !sweep);
endmodule

bind hot_page_tiering hot_tier_checker #(
    .NUM_PAGES(NUM_PAGES), .WARM_CAP(WARM_CAP), .HOT_CAP(HOT_CAP), .PER_W(PER_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .promo_valid(promo_valid), .promo_tier(promo_tier), .demo_mask(demo_mask),
    .sweep(sweep), .sweep_period(sweep_period),
    .warm_occ(warm_occ), .hot_occ(hot_occ)
);

// File: tb/tb_hot_page_tiering.sv
`timescale 1ns/1ps
module tb_hot_page_tiering;
    localparam int NP = 16, CW = 4, WCAP = 4, HCAP = 2, PW = 8;
    localparam int PGW = $clog2(NP);
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [PGW-1:0] acc_page = '0, qry_page = '0;
    logic [CW-1:0] thr_warm = 4'd2, thr_hot = 4'd3;
    logic [PW-1:0] sweep_period = '0;
    logic [1:0] qry_tier, promo_tier;
    logic [CW-1:0] qry_count;
    logic promo_valid;
    logic [PGW-1:0] promo_page;
    logic [NP-1:0] demo_mask;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Behavioural reference state
    int m_tier[NP], m_cnt[NP], m_rd[NP], m_wr[NP];
    int m_wocc, m_hocc, m_tmr;
    int e_pv, e_pp, e_pt;
    logic [NP-1:0] e_dm;

    always #2.5 clk = ~clk;

    hot_page_tiering #(.NUM_PAGES(NP), .CNT_W(CW), .WARM_CAP(WCAP), .HOT_CAP(HCAP), .PER_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
        .acc_write(acc_write), .thr_warm(thr_warm), .thr_hot(thr_hot),
        .sweep_period(sweep_period), .qry_page(qry_page), .qry_tier(qry_tier),
        .qry_count(qry_count), .promo_valid(promo_valid), .promo_page(promo_page),
        .promo_tier(promo_tier), .demo_mask(demo_mask)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model: applies the requirements on every clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_tier[i] = 0; m_cnt[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
            end
            m_wocc = 0; m_hocc = 0; m_tmr = 0; e_pv = 0; e_pp = 0; e_pt = 0; e_dm = '0;
        end else begin
            int per, p, b;
            bit tick;
            per = int'(sweep_period);
            tick = (per != 0) && (m_tmr >= per - 1);
            m_tmr = (per == 0 || tick) ? 0 : m_tmr + 1;
            e_pv = 0; e_dm = '0;
            if (acc_valid) begin
                p = int'(acc_page);
                b = (m_cnt[p] == CMAX) ? CMAX : m_cnt[p] + 1;
                m_cnt[p] = b;
                if (m_tier[p] == 0 && b > int'(thr_warm)) begin
                    if (m_wocc < WCAP) begin
                        m_tier[p] = 1; m_cnt[p] = 0; e_pv = 1; m_wocc++;
                    end else m_cnt[p] = int'(thr_warm);
                end else if (m_tier[p] == 1 && b > int'(thr_hot)) begin
                    if (m_hocc < HCAP) begin
                        m_tier[p] = 2; m_cnt[p] = 0; e_pv = 1; m_wocc--; m_hocc++;
                    end else m_cnt[p] = int'(thr_hot);
                end
                if (acc_write) m_wr[p] = 1; else m_rd[p] = 1;
                e_pp = p; e_pt = m_tier[p];
            end
            if (tick) begin
                for (int i = 0; i < NP; i++) begin
                    if (m_tier[i] != 0 && m_rd[i] == 0 && m_wr[i] == 0) begin
                        e_dm[i] = 1'b1;
                        if (m_tier[i] == 1) m_wocc--; else m_hocc--;
                        m_tier[i] = 0; m_cnt[i] = 0;
                    end
                    m_rd[i] = 0; m_wr[i] = 0;
                end
            end
        end
    end

    // Cycle-by-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3/R4 promo_valid", int'(promo_valid), e_pv);
            if (e_pv != 0) begin
                check("R3/R4 promo_page", int'(promo_page), e_pp);
                check("R3/R4 promo_tier", int'(promo_tier), e_pt);
            end
            check("R6/R7/R8 demo_mask", int'(demo_mask), int'(e_dm));
            check("R2/R9 qry_tier", int'(qry_tier), m_tier[int'(qry_page)]);
            check("R2/R9 qry_count", int'(qry_count), m_cnt[int'(qry_page)]);
        end
    end

    task automatic access(int p, bit wr);
        @(negedge clk); #1;
        acc_valid = 1'b1; acc_page = PGW'(p); acc_write = wr;
        @(negedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic peek(int p, output int t, output int c);
        @(negedge clk); #1;
        qry_page = PGW'(p);
        @(negedge clk);
        t = int'(qry_tier); c = int'(qry_count);
    endtask

    // Advance until the model's timer shows the next edge is a sweep.
    task automatic to_sweep_edge();
        int guard = 0;
        @(negedge clk);
        while (!(int'(sweep_period) != 0 && m_tmr >= int'(sweep_period) - 1) && guard < 400) begin
            @(negedge clk); guard++;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t, c, seen;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 promo_valid after reset", int'(promo_valid), 0);
        check("R1 demo_mask after reset", int'(demo_mask), 0);
        peek(9, t, c);
        check("R1 reset tier", t, 0);
        check("R1 reset count", c, 0);

        access(1, 0); access(1, 0);
        peek(1, t, c);
        check("R2 count after two hits", c, 2);
        access(1, 0);
        check("R3 promo_valid", int'(promo_valid), 1);
        check("R3 promo_tier", int'(promo_tier), 1);
        check("R3 promo_page", int'(promo_page), 1);
        peek(1, t, c);
        check("R3 warm count cleared", c, 0);

        repeat (3) access(1, 1);
        access(1, 1);
        check("R4 promo_tier hot", int'(promo_tier), 2);
        check("R4 promo_valid", int'(promo_valid), 1);

        for (int p = 2; p <= 5; p++) repeat (3) access(p, 0);
        access(6, 0); access(6, 0); access(6, 0);
        check("R5 deferred no event", int'(promo_valid), 0);
        peek(6, t, c);
        check("R5 deferred stays coarse", t, 0);
        check("R5 count clamped to threshold", c, 2);

        repeat (20) access(1, 0);
        peek(1, t, c);
        check("R9 saturated count", c, CMAX);
        check("R9 hot stays hot", t, 2);

        // First sweep: every flag set since reset, nothing demoted.
        sweep_period = PW'(30);
        to_sweep_edge();
        @(negedge clk);
        check("R7 first sweep keeps all", int'(demo_mask), 0);
        access(2, 1); access(3, 0);
        to_sweep_edge();
        @(negedge clk);
        check("R6/R7 second sweep mask", int'(demo_mask), 16'h0032);
        peek(4, t, c);
        check("R6 demoted to coarse", t, 0);
        peek(2, t, c);
        check("R6 write flag keeps page warm", t, 1);

        access(6, 0);
        check("R5 retry promotes", int'(promo_valid), 1);
        check("R5 retry tier", int'(promo_tier), 1);

        // Access exactly on the sweep edge.
        to_sweep_edge();
        #1 acc_valid = 1'b1; acc_page = PGW'(2); acc_write = 1'b0;
        @(negedge clk);
        check("R10 same-edge access survives", int'(demo_mask), 16'h0008);
        #1 acc_valid = 1'b0;
        peek(2, t, c);
        check("R10 page still warm", t, 1);

        sweep_period = '0;
        seen = 0;
        repeat (100) begin
            @(negedge clk);
            if (demo_mask != '0) seen++;
        end
        check("R8 period zero no demotion", seen, 0);

        // Mixed random traffic checked cycle by cycle against the model.
        sweep_period = PW'(23); thr_warm = 4'd3; thr_hot = 4'd5;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk); #1;
            acc_valid = $urandom_range(0, 1) == 1;
            acc_page = PGW'($urandom_range(0, NP - 1));
            acc_write = $urandom_range(0, 1) == 1;
            qry_page = PGW'($urandom_range(0, NP - 1));
            if (k == 1500) begin thr_warm = 4'd1; thr_hot = 4'd2; sweep_period = PW'(9); end
        end
        @(negedge clk); #1 acc_valid = 1'b0;
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule